// File: doc/BRIEF.md
# Power-Management Function Configuration Logic

This block holds the configuration registers of a power-management function that sits on a PCI-style configuration path. Software places two I/O windows through these registers: a 128-byte window for the power-management register file and a 16-byte window for the SMBus host. Each window has its own base register and its own enable bit. The block drives each base and enable straight to the address decoders that route I/O cycles.

The block also builds the system control interrupt (SCI). It takes the event status and event enable words from the PM1 event register file. It raises SCI when one of four interrupt-capable events is both pending and enabled, and only if the function's interrupt-pin byte is nonzero. It also tells the timer logic when a counter rollover may interrupt. It flags each rollover of the 24-bit counter's top bit that occurs while rollover interrupts are armed.

Configuration accesses are 32-bit wide, addressed by dword index, and carry a 4-bit byte-enable. Lane k covers data bits 8k+7..8k. Reads return the addressed dword combinationally. Writes take effect on the rising clock edge.

Top module: `pm_function_regs`

## Requirements
- R1: PM base (byte offset 0x48, dword 0x12) keeps only bits 15..7. Lane 0 writes bit 7 and lane 1 writes bits 15..8. Reads return bits 15..7 as stored, with bit 0 as 1 and every other bit 0. `pmWinBase` equals the stored bits with bits 6..0 zero.
- R2: Byte 0x41 (dword 0x10, lane 1) is stored in full and read back in bits 15..8. `pmWinEn` follows its bit 7.
- R3: SMBus base (byte offset 0x90, dword 0x24) keeps only bits 15..4, written per lane as in R1. Reads return bit 0 as 1 and bits 3..1 and 31..16 as 0. `smbWinBase` equals the stored bits with bits 3..0 zero.
- R4: A write to byte 0xD2 (dword 0x34, lane 2) stores only its low four bits, and the upper nibble reads 0. `smbWinEn` follows bit 0 of that byte.
- R5: `sci` is high when (evtSts & evtEn) has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC) set. No other event bit affects it. It responds in the same cycle, with no register stage.
- R6: The interrupt-pin byte (0x3D, dword 0x0F, lane 1) is writable and reads back in bits 15..8. While it is 0, `sci` stays low.
- R7: After reset, both base dwords read 0x00000001, bytes 0x41 and 0xD2 read 0, both windows are disabled, and the interrupt-pin byte holds its reset parameter (default 0x01).
- R8: `tmrArm` is high exactly when evtEn bit 0 is 1 and evtSts bit 0 is 0. `tmrWrap` pulses for one cycle, one clock after an edge that samples `tmrMsb` changed while `tmrArm` was high.
- R9: A write changes only the bytes whose lane enable is set. Dwords with no implemented field read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDw | input | 6 | Configuration dword index |
| cfgByteEn | input | 4 | Byte-lane enables for a write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data of the addressed dword |
| evtSts | input | 16 | PM1 event status bits |
| evtEn | input | 16 | PM1 event enable bits |
| tmrMsb | input | 1 | Top bit of the 24-bit power-management counter |
| pmWinBase | output | 16 | PM I/O window base |
| pmWinEn | output | 1 | PM I/O window decode enable |
| smbWinBase | output | 16 | SMBus I/O window base |
| smbWinEn | output | 1 | SMBus I/O window decode enable |
| sci | output | 1 | System control interrupt |
| tmrArm | output | 1 | Counter rollover may interrupt |
| tmrWrap | output | 1 | One-cycle rollover flag while armed |

## Verification
The register masks are tested with random dword indices, mostly aimed at the five implemented dwords, and with random data and random byte-enable patterns. This separates true per-lane merging from whole-dword writes. It also shows that each forced bit (bit 0 set, alignment bits cleared, upper nibble of 0xD2 cleared) reappears after every overlapping write. The SCI combination is tested with random status and enable words and a randomly rewritten interrupt-pin byte. Directed cases then put each of the four qualifying events alone and a non-qualifying event alone. These cases separate a correct event mask from a mask that is too wide or too narrow. Counter rollover is toggled once with the timer armed and once with it disarmed, to show that the arming condition really gates `tmrWrap`.

// File: rtl/pm_fn_pkg.sv
package pm_fn_pkg;
  localparam int IO_W     = 16;
  localparam int IO_LANES = IO_W / 8;
  localparam logic [15:0] SCI_EVT_MASK = 16'h0521;

  typedef struct packed {
    logic                wrIntPin;
    logic                wrPmCtl;
    logic [IO_LANES-1:0] wrPmBase;
    logic [IO_LANES-1:0] wrSmbBase;
    logic                wrSmbCtl;
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO, RD_INTPIN, RD_PMCTL, RD_PMBASE, RD_SMBBASE, RD_SMBCTL
  } rdSel_e;
endpackage

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode
  import pm_fn_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] INTPIN_OFS  = 8'h3D,
  parameter logic [CFG_AW-1:0] PMCTL_OFS   = 8'h41,
  parameter logic [CFG_AW-1:0] PMBASE_OFS  = 8'h48,
  parameter logic [CFG_AW-1:0] SMBBASE_OFS = 8'h90,
  parameter logic [CFG_AW-1:0] SMBCTL_OFS  = 8'hD2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-3:0] cfgDw,
  input  logic [3:0]        cfgByteEn,
  output cfgStrobe_t        stb,
  output rdSel_e            rdSel
);
  localparam logic [CFG_AW-3:0] INTPIN_DW  = INTPIN_OFS[CFG_AW-1:2];
  localparam logic [CFG_AW-3:0] PMCTL_DW   = PMCTL_OFS[CFG_AW-1:2];
  localparam logic [CFG_AW-3:0] PMBASE_DW  = PMBASE_OFS[CFG_AW-1:2];
  localparam logic [CFG_AW-3:0] SMBBASE_DW = SMBBASE_OFS[CFG_AW-1:2];
  localparam logic [CFG_AW-3:0] SMBCTL_DW  = SMBCTL_OFS[CFG_AW-1:2];

  logic hitIntPin, hitPmCtl, hitPmBase, hitSmbBase, hitSmbCtl;

  always_comb begin
    hitIntPin  = (cfgDw == INTPIN_DW);
    hitPmCtl   = (cfgDw == PMCTL_DW);
    hitPmBase  = (cfgDw == PMBASE_DW);
    hitSmbBase = (cfgDw == SMBBASE_DW);
    hitSmbCtl  = (cfgDw == SMBCTL_DW);
  end

  always_comb begin
    stb = '0;
    if (cfgWrEn) begin
      stb.wrIntPin = hitIntPin && cfgByteEn[INTPIN_OFS[1:0]];
      stb.wrPmCtl  = hitPmCtl  && cfgByteEn[PMCTL_OFS[1:0]];
      stb.wrSmbCtl = hitSmbCtl && cfgByteEn[SMBCTL_OFS[1:0]];
      for (int l = 0; l < IO_LANES; l++) begin
        stb.wrPmBase[l]  = hitPmBase  && cfgByteEn[l];
        stb.wrSmbBase[l] = hitSmbBase && cfgByteEn[l];
      end
    end
  end

  always_comb begin
    if (hitIntPin)       rdSel = RD_INTPIN;
    else if (hitPmCtl)   rdSel = RD_PMCTL;
    else if (hitPmBase)  rdSel = RD_PMBASE;
    else if (hitSmbBase) rdSel = RD_SMBBASE;
    else if (hitSmbCtl)  rdSel = RD_SMBCTL;
    else                 rdSel = RD_ZERO;
  end

  // R9: one write never reaches two register fields
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrIntPin, stb.wrPmCtl, |stb.wrPmBase, |stb.wrSmbBase, stb.wrSmbCtl}));
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_fn_pkg::*;
#(
  parameter int PM_ALIGN     = 7,
  parameter int SMB_ALIGN    = 4,
  parameter int PM_EN_BIT    = 7,
  parameter int SMB_EN_BIT   = 0,
  parameter int SMB_CTL_KEEP = 4,
  parameter logic [7:0] INT_PIN_RST = 8'h01,
  parameter int INTPIN_LANE  = 1,
  parameter int PMCTL_LANE   = 1,
  parameter int SMBCTL_LANE  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       stb,
  input  rdSel_e           rdSel,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic [IO_W-1:0]  pmWinBase,
  output logic             pmWinEn,
  output logic [IO_W-1:0]  smbWinBase,
  output logic             smbWinEn,
  output logic [7:0]       intPin
);
  logic [7:0]              intPinQ, pmCtlQ;
  logic [SMB_CTL_KEEP-1:0] smbCtlQ;
  logic [IO_W-1:PM_ALIGN]  pmBaseQ, pmBaseD;
  logic [IO_W-1:SMB_ALIGN] smbBaseQ, smbBaseD;

  // per-bit lane merge keeps only the bits above the window alignment
  always_comb begin
    pmBaseD  = pmBaseQ;
    smbBaseD = smbBaseQ;
    for (int b = PM_ALIGN; b < IO_W; b++)
      if (stb.wrPmBase[b >> 3]) pmBaseD[b] = wrData[b];
    for (int b = SMB_ALIGN; b < IO_W; b++)
      if (stb.wrSmbBase[b >> 3]) smbBaseD[b] = wrData[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intPinQ  <= INT_PIN_RST;
      pmCtlQ   <= '0;
      smbCtlQ  <= '0;
      pmBaseQ  <= '0;
      smbBaseQ <= '0;
    end else begin
      if (stb.wrIntPin) intPinQ <= wrData[8*INTPIN_LANE +: 8];
      if (stb.wrPmCtl)  pmCtlQ  <= wrData[8*PMCTL_LANE +: 8];
      if (stb.wrSmbCtl) smbCtlQ <= wrData[8*SMBCTL_LANE +: SMB_CTL_KEEP];
      pmBaseQ  <= pmBaseD;
      smbBaseQ <= smbBaseD;
    end
  end

  always_comb begin
    case (rdSel)
      RD_INTPIN:  rdData = 32'(intPinQ) << (8*INTPIN_LANE);
      RD_PMCTL:   rdData = 32'(pmCtlQ) << (8*PMCTL_LANE);
      RD_SMBCTL:  rdData = 32'(smbCtlQ) << (8*SMBCTL_LANE);
      RD_PMBASE:  rdData = 32'({pmBaseQ, {(PM_ALIGN-1){1'b0}}, 1'b1});
      RD_SMBBASE: rdData = 32'({smbBaseQ, {(SMB_ALIGN-1){1'b0}}, 1'b1});
      default:    rdData = '0;
    endcase
  end

  assign pmWinBase  = {pmBaseQ, {PM_ALIGN{1'b0}}};
  assign smbWinBase = {smbBaseQ, {SMB_ALIGN{1'b0}}};
  assign pmWinEn    = pmCtlQ[PM_EN_BIT];
  assign smbWinEn   = smbCtlQ[SMB_EN_BIT];
  assign intPin     = intPinQ;

  // R2: PM window enable only moves on a write to its control byte
  p_pm_en_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrPmCtl |=> $stable(pmWinEn));
  // R4: SMBus window enable only moves on a write to its control byte
  p_smb_en_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrSmbCtl |=> $stable(smbWinEn));
  // R4: the upper part of the SMBus control byte never reads back set
  p_smb_ctl_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == RD_SMBCTL) |-> (rdData[8*SMBCTL_LANE+SMB_CTL_KEEP +: (8-SMB_CTL_KEEP)] == '0));
  // R7: both windows come out of reset closed
  p_reset_closed_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!pmWinEn && !smbWinEn));
endmodule

// File: rtl/pm_sci_gate.sv
module pm_sci_gate
  import pm_fn_pkg::*;
#(
  parameter int EVT_W   = 16,
  parameter logic [EVT_W-1:0] EVT_MASK = SCI_EVT_MASK,
  parameter int TMR_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtSts,
  input  logic [EVT_W-1:0] evtEn,
  input  logic [7:0]       intPin,
  input  logic             tmrMsb,
  output logic             sci,
  output logic             tmrArm,
  output logic             tmrWrap
);
  logic pending, prevMsb;

  always_comb begin
    pending = |(evtSts & evtEn & EVT_MASK);
    sci     = pending && (intPin != 8'h00);
    tmrArm  = evtEn[TMR_BIT] && !evtSts[TMR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMsb <= 1'b0;
      tmrWrap <= 1'b0;
    end else begin
      prevMsb <= tmrMsb;
      tmrWrap <= tmrArm && (tmrMsb != prevMsb);
    end
  end

  // R6: no interrupt while the pin byte is zero
  p_pin_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intPin == 8'h00) |-> !sci);
  // R5: no interrupt without a qualifying pending event
  p_evt_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtSts & evtEn & EVT_MASK) == '0) |-> !sci);
  // R8: a rollover flag needs the arming condition one cycle earlier
  p_wrap_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    tmrWrap |-> $past(tmrArm));
endmodule

// File: rtl/pm_function_regs.sv
module pm_function_regs
  import pm_fn_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] INTPIN_OFS  = 8'h3D,
  parameter logic [CFG_AW-1:0] PMCTL_OFS   = 8'h41,
  parameter logic [CFG_AW-1:0] PMBASE_OFS  = 8'h48,
  parameter logic [CFG_AW-1:0] SMBBASE_OFS = 8'h90,
  parameter logic [CFG_AW-1:0] SMBCTL_OFS  = 8'hD2,
  parameter int PM_WIN_BYTES  = 128,
  parameter int SMB_WIN_BYTES = 16,
  parameter logic [7:0] INT_PIN_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-3:0] cfgDw,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [15:0]       evtSts,
  input  logic [15:0]       evtEn,
  input  logic              tmrMsb,
  output logic [15:0]       pmWinBase,
  output logic              pmWinEn,
  output logic [15:0]       smbWinBase,
  output logic              smbWinEn,
  output logic              sci,
  output logic              tmrArm,
  output logic              tmrWrap
);
  localparam int PM_ALIGN  = $clog2(PM_WIN_BYTES);
  localparam int SMB_ALIGN = $clog2(SMB_WIN_BYTES);

  cfgStrobe_t stb;
  rdSel_e     rdSel;
  logic [7:0] intPin;

  pm_cfg_decode #(
    .CFG_AW(CFG_AW), .INTPIN_OFS(INTPIN_OFS), .PMCTL_OFS(PMCTL_OFS),
    .PMBASE_OFS(PMBASE_OFS), .SMBBASE_OFS(SMBBASE_OFS), .SMBCTL_OFS(SMBCTL_OFS)
  ) i_decode (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgDw(cfgDw),
    .cfgByteEn(cfgByteEn), .stb(stb), .rdSel(rdSel)
  );

  pm_cfg_regs #(
    .PM_ALIGN(PM_ALIGN), .SMB_ALIGN(SMB_ALIGN), .INT_PIN_RST(INT_PIN_RST),
    .INTPIN_LANE(int'(INTPIN_OFS[1:0])), .PMCTL_LANE(int'(PMCTL_OFS[1:0])),
    .SMBCTL_LANE(int'(SMBCTL_OFS[1:0]))
  ) i_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(cfgWrData),
    .rdData(cfgRdData), .pmWinBase(pmWinBase), .pmWinEn(pmWinEn),
    .smbWinBase(smbWinBase), .smbWinEn(smbWinEn), .intPin(intPin)
  );

  pm_sci_gate #(.EVT_W(16)) i_sci (
    .clk(clk), .rstN(rstN), .evtSts(evtSts), .evtEn(evtEn), .intPin(intPin),
    .tmrMsb(tmrMsb), .sci(sci), .tmrArm(tmrArm), .tmrWrap(tmrWrap)
  );

  // R1: PM base dword always reads with bit 0 set and alignment bits clear
  p_pm_rd_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDw == PMBASE_OFS[CFG_AW-1:2]) |-> (cfgRdData[PM_ALIGN-1:0] == PM_ALIGN'(1)));
  // R3: SMBus base dword always reads with bit 0 set and alignment bits clear
  p_smb_rd_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDw == SMBBASE_OFS[CFG_AW-1:2]) |-> (cfgRdData[SMB_ALIGN-1:0] == SMB_ALIGN'(1)));
endmodule

// File: tb/test_pm_function_regs.sv
module test_pm_function_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgDw = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [15:0] evtSts = '0, evtEn = '0;
  logic        tmrMsb = 1'b0;
  logic [15:0] pmWinBase, smbWinBase;
  logic        pmWinEn, smbWinEn, sci, tmrArm, tmrWrap;

  int checkCnt = 0, failCnt = 0;
  bit done = 0;

  logic [7:0]  mIntPin = 8'h01, mPmCtl = 8'h00, mSmbCtl = 8'h00;
  logic [15:0] mPm = 16'h0, mSmb = 16'h0;

  always #2.5 clk = ~clk;

  pm_function_regs i_pm_function_regs (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [5:0] dw);
    case (dw)
      6'h0F:   return {16'h0, mIntPin, 8'h0};
      6'h10:   return {16'h0, mPmCtl, 8'h0};
      6'h12:   return {16'h0, mPm | 16'h1};
      6'h24:   return {16'h0, mSmb | 16'h1};
      6'h34:   return {8'h0, mSmbCtl, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expSci(logic [15:0] s, logic [15:0] e, logic [7:0] pin);
    return (pin != 8'h0) && (((s & e) & 16'h0521) != 16'h0);
  endfunction

  task automatic modelWrite(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    case (dw)
      6'h0F: if (be[1]) mIntPin = d[15:8];
      6'h10: if (be[1]) mPmCtl = d[15:8];
      6'h12: begin
        if (be[0]) mPm[7:0] = d[7:0];
        if (be[1]) mPm[15:8] = d[15:8];
        mPm &= 16'hFF80;
      end
      6'h24: begin
        if (be[0]) mSmb[7:0] = d[7:0];
        if (be[1]) mSmb[15:8] = d[15:8];
        mSmb &= 16'hFFF0;
      end
      6'h34: if (be[2]) mSmbCtl = {4'h0, d[19:16]};
      default: ;
    endcase
  endtask

  task automatic cfgWrite(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDw = dw; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    modelWrite(dw, be, d);
  endtask

  task automatic readCheck(logic [5:0] dw, string req);
    @(negedge clk);
    cfgDw = dw;
    #1;
    check(req, cfgRdData, expRead(dw));
  endtask

  task automatic checkAll();
    readCheck(6'h12, "R1 pm base read");
    readCheck(6'h10, "R2 pm ctl read");
    readCheck(6'h24, "R3 smb base read");
    readCheck(6'h34, "R4 smb ctl read");
    readCheck(6'h0F, "R6 int pin read");
    check("R1 pmWinBase", 32'(pmWinBase), 32'(mPm));
    check("R2 pmWinEn", 32'(pmWinEn), 32'(mPmCtl[7]));
    check("R3 smbWinBase", 32'(smbWinBase), 32'(mSmb));
    check("R4 smbWinEn", 32'(smbWinEn), 32'(mSmbCtl[0]));
  endtask

  task automatic sciCheck(logic [15:0] s, logic [15:0] e, string req);
    @(negedge clk);
    evtSts = s; evtEn = e;
    #1;
    check(req, 32'(sci), 32'(expSci(s, e, mIntPin)));
    check("R8 tmrArm", 32'(tmrArm), 32'(e[0] && !s[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [5:0] hot [5];
    hot[0] = 6'h0F; hot[1] = 6'h10; hot[2] = 6'h12; hot[3] = 6'h24; hot[4] = 6'h34;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R7: reset state
    readCheck(6'h12, "R7 pm base reset");
    readCheck(6'h24, "R7 smb base reset");
    readCheck(6'h10, "R7 pm ctl reset");
    readCheck(6'h34, "R7 smb ctl reset");
    readCheck(6'h0F, "R7 int pin reset");
    check("R7 windows closed", 32'({pmWinEn, smbWinEn}), 32'h0);

    // R1/R3 directed: all ones, then a partial-lane write
    cfgWrite(6'h12, 4'hF, 32'hFFFF_FFFF);
    readCheck(6'h12, "R1 all ones");
    cfgWrite(6'h12, 4'h1, 32'h0000_0000);
    readCheck(6'h12, "R9 lane0 only");
    check("R1 base after lane0", 32'(pmWinBase), 32'hFF00);
    cfgWrite(6'h24, 4'hF, 32'hFFFF_FFFF);
    readCheck(6'h24, "R3 all ones");
    cfgWrite(6'h24, 4'h2, 32'h0000_1200);
    readCheck(6'h24, "R9 lane1 only");
    // R4 directed: upper nibble dropped
    cfgWrite(6'h34, 4'h4, 32'h00FF_0000);
    readCheck(6'h34, "R4 nibble cleared");
    check("R4 smbWinEn set", 32'(smbWinEn), 32'h1);
    cfgWrite(6'h34, 4'hB, 32'hFFFE_FFFF);
    readCheck(6'h34, "R9 lane2 masked");
    // R2 directed
    cfgWrite(6'h10, 4'h2, 32'h0000_8000);
    check("R2 pm window open", 32'(pmWinEn), 32'h1);
    // R9: unimplemented dword ignored
    cfgWrite(6'h11, 4'hF, 32'hFFFF_FFFF);
    readCheck(6'h11, "R9 unimplemented dword");
    checkAll();

    // random register traffic
    for (int i = 0; i < 300; i++) begin
      logic [5:0] dw;
      dw = ($urandom_range(0, 9) < 7) ? hot[$urandom_range(0, 4)] : 6'($urandom);
      cfgWrite(dw, 4'($urandom), $urandom);
      checkAll();
      readCheck(6'($urandom), "R9 random dword");
    end

    // SCI directed (R5, R6)
    cfgWrite(6'h0F, 4'h2, 32'h0000_0100);
    sciCheck(16'h0001, 16'h0001, "R5 timer event");
    sciCheck(16'h0020, 16'h0020, "R5 global lock event");
    sciCheck(16'h0100, 16'h0100, "R5 power button event");
    sciCheck(16'h0400, 16'h0400, "R5 rtc event");
    sciCheck(16'hFADE, 16'h0521 ^ 16'hFFFF, "R5 other bits ignored");
    sciCheck(16'h0400, 16'hFBFF, "R5 enable required");
    cfgWrite(6'h0F, 4'h2, 32'h0000_0000);
    sciCheck(16'hFFFF, 16'hFFFF, "R6 zero pin gates sci");
    check("R6 sci low", 32'(sci), 32'h0);

    // SCI random
    for (int i = 0; i < 400; i++) begin
      if (i % 20 == 0)
        cfgWrite(6'h0F, 4'h2, ($urandom_range(0, 2) == 0) ? 32'h0 : {16'h0, 8'($urandom), 8'h0});
      sciCheck(16'($urandom), 16'($urandom), "R5 random sci");
    end

    // R8: rollover armed and disarmed
    @(negedge clk); evtEn = 16'h0001; evtSts = 16'h0000; tmrMsb = 1'b0;
    @(negedge clk); tmrMsb = 1'b1;
    @(negedge clk); check("R8 wrap armed", 32'(tmrWrap), 32'h1);
    @(negedge clk); check("R8 wrap one cycle", 32'(tmrWrap), 32'h0);
    evtSts = 16'h0001;
    @(negedge clk); tmrMsb = 1'b0;
    @(negedge clk); check("R8 wrap disarmed", 32'(tmrWrap), 32'h0);
    @(negedge clk); check("R8 wrap disarmed later", 32'(tmrWrap), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule